// File: doc/BRIEF.md
# SIMD Saturating Add/Subtract Unit

This unit performs element-wise saturating addition or subtraction on two 128-bit source vectors. A 6-bit minor opcode picks three things: add or subtract, signed or unsigned clamping, and a lane width of 8, 16 or 32 bits. Each lane computes its plain wrap-around result and its clamped result. A lane has saturated when the two differ. The datapath is combinational, so the result appears in the same cycle as the operands.

The saturation flags of all lanes are ORed together. When a valid, legal instruction is presented, that OR is accumulated into a registered sticky status bit. Arithmetic never clears the bit; only a dedicated clear input does. Two conditions suppress the result and raise an output instead of writing anything:

- a disabled vector facility raises an unavailable trap;
- an unknown opcode raises an illegal-opcode output.

Top module: `simd_sat_unit`

## Requirements
- R1: Operands and the result are 128 bits, split into independent lanes; lane i occupies bits [i*W+W-1 : i*W], and a carry or clamp in one lane never affects another lane.
- R2: Unsigned saturating add (opcodes 8, 9, 10 for W = 8, 16, 32) clamps a lane to all-ones when the true sum exceeds 2^W-1.
- R3: Signed saturating add (opcodes 12, 13, 14 for W = 8, 16, 32) clamps a lane to the most positive or most negative two's-complement value of W bits when the true sum is out of range.
- R4: Unsigned saturating subtract (opcodes 24, 25, 26 for W = 8, 16, 32) clamps a lane to 0 when b exceeds a.
- R5: Signed saturating subtract (opcodes 28, 29, 30 for W = 8, 16, 32) clamps a lane to the most positive or most negative W-bit value when a-b is out of range.
- R6: Opcode bits [1:0] choose the lane width (0 means 8, 1 means 16, 2 means 32), so the same operands give different results at different widths.
- R7: On a clock edge where result_valid is high and any lane's clamped value differs from its wrap-around value, sat_sticky becomes 1. Once set, it stays 1 through later arithmetic, including operations that do not saturate.
- R8: sat_clr forces sat_sticky to 0 on the next edge and takes priority over a simultaneous set.
- R9: With op_valid high and vec_en low, unavail_trap is 1, result is 0, result_valid is 0, and sat_sticky is unchanged.
- R10: An opcode outside the twelve listed, presented with op_valid and vec_en high, gives illegal_op = 1, result = 0 and result_valid = 0, and leaves sat_sticky unchanged.
- R11: After synchronous reset, sat_sticky is 0, and with op_valid low all outputs other than sat_sticky are 0.
- R12: result and result_valid are combinational in the inputs and settle in the same cycle. At most one of result_valid, illegal_op and unavail_trap is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_en | input | 1 | Vector facility enable |
| op_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 6 | Minor opcode |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector (subtrahend for subtract) |
| sat_clr | input | 1 | Clear the sticky saturation bit |
| result | output | 128 | Lane-wise saturated result, 0 when not valid |
| result_valid | output | 1 | Result is to be written |
| unavail_trap | output | 1 | Instruction issued while the facility is disabled |
| illegal_op | output | 1 | Unrecognised opcode |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The vector result and the three qualifier outputs are due in the same cycle as their inputs. The sticky bit changes only at the following rising edge. The bench drives inputs just after a falling edge and reads result, result_valid, illegal_op and unavail_trap one nanosecond later, before any edge. It then waits for the next rising edge and reads sat_sticky one nanosecond after it. Each table vector starts from a cleared sticky bit, so the sticky value read afterwards belongs to that vector alone.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

    localparam int VEC_W   = 128;
    localparam int OPC_W   = 6;
    localparam int N_WIDTH = 3;

    typedef enum logic [1:0] {
        LW8  = 2'd0,
        LW16 = 2'd1,
        LW32 = 2'd2
    } lane_w_e;

    typedef struct packed {
        logic    legal;
        logic    sub;
        logic    sgn;
        lane_w_e width;
    } sat_op_t;

    // Encoding: bit5=0, bit4=subtract, bit3=1, bit2=signed, bits1:0=width (3 illegal)
    function automatic sat_op_t decode_op(input logic [OPC_W-1:0] opc);
        sat_op_t d;
        d.sub   = opc[4];
        d.sgn   = opc[2];
        d.width = lane_w_e'(opc[1:0]);
        d.legal = (opc[5] == 1'b0) && (opc[3] == 1'b1) && (opc[1:0] != 2'b11);
        return d;
    endfunction

endpackage

// File: rtl/simd_sat_decode.sv
module simd_sat_decode
    import simd_sat_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output sat_op_t          dec
);
    always_comb dec = decode_op(opcode);
endmodule

// File: rtl/simd_sat_lane.sv
module simd_sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    output logic [W-1:0] res,
    output logic         sat
);
    logic [W:0]   ea, eb, ext;
    logic [W-1:0] wrap, clamp;

    always_comb begin
        ea    = sgn ? {a[W-1], a} : {1'b0, a};
        eb    = sgn ? {b[W-1], b} : {1'b0, b};
        ext   = sub ? (ea - eb) : (ea + eb);
        wrap  = ext[W-1:0];
        clamp = wrap;
        if (sgn) begin
            if (ext[W] != ext[W-1])
                clamp = ext[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            if (ext[W])
                clamp = sub ? {W{1'b0}} : {W{1'b1}};
        end
        res = clamp;
        sat = (clamp != wrap);
    end
endmodule

// File: rtl/simd_sat_sticky.sv
module simd_sat_sticky (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end
endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
    import simd_sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vec_en,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             sat_clr,
    output logic [VEC_W-1:0] result,
    output logic             result_valid,
    output logic             unavail_trap,
    output logic             illegal_op,
    output logic             sat_sticky
);
    sat_op_t          dec;
    logic [VEC_W-1:0] res_w [N_WIDTH];
    logic             sat_w [N_WIDTH];
    logic [VEC_W-1:0] res_sel;
    logic             sat_sel;

    simd_sat_decode u_dec (.opcode(opcode), .dec(dec));

    for (genvar gw = 0; gw < N_WIDTH; gw++) begin : g_width
        localparam int W = 8 << gw;
        localparam int N = VEC_W / W;
        logic [N-1:0] lane_sat;
        for (genvar gl = 0; gl < N; gl++) begin : g_lane
            simd_sat_lane #(.W(W)) u_lane (
                .a   (src_a[gl*W +: W]),
                .b   (src_b[gl*W +: W]),
                .sub (dec.sub),
                .sgn (dec.sgn),
                .res (res_w[gw][gl*W +: W]),
                .sat (lane_sat[gl])
            );
        end
        assign sat_w[gw] = |lane_sat;
    end

    always_comb begin
        unique case (dec.width)
            LW8:     begin res_sel = res_w[0]; sat_sel = sat_w[0]; end
            LW16:    begin res_sel = res_w[1]; sat_sel = sat_w[1]; end
            LW32:    begin res_sel = res_w[2]; sat_sel = sat_w[2]; end
            default: begin res_sel = '0;       sat_sel = 1'b0;     end
        endcase
    end

    always_comb begin
        unavail_trap = op_valid && !vec_en;
        illegal_op   = op_valid && vec_en && !dec.legal;
        result_valid = op_valid && vec_en && dec.legal;
        result       = result_valid ? res_sel : '0;
    end

    simd_sat_sticky u_sticky (
        .clk (clk),
        .rst (rst),
        .clr (sat_clr),
        .set (result_valid && sat_sel),
        .q   (sat_sticky)
    );
endmodule

// File: rtl/simd_sat_unit_chk.sv
module simd_sat_unit_chk
    import simd_sat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             vec_en,
    input logic             op_valid,
    input logic             sat_clr,
    input logic [VEC_W-1:0] result,
    input logic             result_valid,
    input logic             unavail_trap,
    input logic             illegal_op,
    input logic             sat_sticky
);
    // R9
    unavail_out_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !vec_en) |-> (unavail_trap && !result_valid && result == '0));

    // R9
    unavail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unavail_trap && !sat_clr) |=> $stable(sat_sticky));

    // R10
    illegal_out_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (result == '0 && !result_valid));

    // R10
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_op && !sat_clr) |=> $stable(sat_sticky));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sat_clr |=> !sat_sticky);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !sat_clr) |=> sat_sticky);

    // R7
    sticky_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_sticky) |-> $past(result_valid));

    // R12
    qual_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({result_valid, illegal_op, unavail_trap}));
endmodule

bind simd_sat_unit simd_sat_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vec_en       (vec_en),
    .op_valid     (op_valid),
    .sat_clr      (sat_clr),
    .result       (result),
    .result_valid (result_valid),
    .unavail_trap (unavail_trap),
    .illegal_op   (illegal_op),
    .sat_sticky   (sat_sticky)
);

// File: tb/simd_sat_unit_tb.sv
`timescale 1ns/1ps
module simd_sat_unit_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vec_en = 1'b1;
    logic         op_valid = 1'b0;
    logic [5:0]   opcode = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         sat_clr = 1'b0;
    logic [127:0] result;
    logic         result_valid, unavail_trap, illegal_op, sat_sticky;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    simd_sat_unit u_dut (
        .clk(clk), .rst(rst), .vec_en(vec_en), .op_valid(op_valid),
        .opcode(opcode), .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
        .result(result), .result_valid(result_valid),
        .unavail_trap(unavail_trap), .illegal_op(illegal_op),
        .sat_sticky(sat_sticky)
    );

    typedef struct packed {
        logic [5:0]   op;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic         sat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        // R1 R2: mixed lanes, unsigned byte add
        '{6'd8,  {8{8'hF0, 8'h10}}, {16{8'h20}}, {8{8'hFF, 8'h30}}, 1'b1},
        '{6'd8,  {16{8'h01}}, {16{8'h02}}, {16{8'h03}}, 1'b0},
        // R2 R6: unsigned half add
        '{6'd9,  {8{16'hFFF0}}, {8{16'h0020}}, {8{16'hFFFF}}, 1'b1},
        // R2 R6: unsigned word add, no overflow
        '{6'd10, {4{32'h7FFFFFFF}}, {4{32'h1}}, {4{32'h80000000}}, 1'b0},
        // R3: signed word add overflow
        '{6'd14, {4{32'h7FFFFFFF}}, {4{32'h1}}, {4{32'h7FFFFFFF}}, 1'b1},
        // R3: signed byte add underflow
        '{6'd12, {16{8'h80}}, {16{8'hFF}}, {16{8'h80}}, 1'b1},
        '{6'd13, {8{16'h1234}}, {8{16'h1111}}, {8{16'h2345}}, 1'b0},
        // R4: unsigned byte sub, mixed lanes
        '{6'd24, {8{8'h05, 8'h10}}, {16{8'h08}}, {8{8'h00, 8'h08}}, 1'b1},
        // R4 R6: unsigned half sub across byte boundary
        '{6'd25, {8{16'h0100}}, {8{16'h0001}}, {8{16'h00FF}}, 1'b0},
        '{6'd26, 128'h0, {4{32'h1}}, 128'h0, 1'b1},
        // R5: signed byte sub overflow
        '{6'd28, {16{8'h7F}}, {16{8'h80}}, {16{8'h7F}}, 1'b1},
        // R5: signed half sub underflow
        '{6'd29, {8{16'h8000}}, {8{16'h0001}}, {8{16'h8000}}, 1'b1},
        '{6'd30, {4{32'hFFFFFFFE}}, {4{32'h3}}, {4{32'hFFFFFFFB}}, 1'b0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_sticky();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
    endtask

    // Drive at negedge, sample combinational outputs 1 ns later.
    task automatic apply(input logic [5:0] op, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        opcode = op; src_a = a; src_b = b; op_valid = 1'b1;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11 sticky", {127'b0, sat_sticky}, 128'h0);
        chk("R11 outputs", {124'b0, result_valid, unavail_trap, illegal_op, |result}, 128'h0);

        for (int i = 0; i < NV; i++) begin
            clear_sticky();
            apply(TBL[i].op, TBL[i].a, TBL[i].b);
            chk($sformatf("R1-vec%0d result (R12)", i), result, TBL[i].exp);
            chk("R12 result_valid", {127'b0, result_valid}, 128'h1);
            after_edge();
            chk($sformatf("R7 sticky vec%0d", i), {127'b0, sat_sticky}, {127'b0, TBL[i].sat});
        end

        // R7: sticky persists across a non-saturating op
        clear_sticky();
        apply(6'd8, {16{8'hFF}}, {16{8'h01}});
        after_edge();
        apply(6'd8, {16{8'h01}}, {16{8'h01}});
        after_edge();
        chk("R7 sticky hold", {127'b0, sat_sticky}, 128'h1);

        // R8: clear wins over simultaneous set
        @(negedge clk);
        sat_clr = 1'b1;
        opcode = 6'd8; src_a = {16{8'hFF}}; src_b = {16{8'hFF}}; op_valid = 1'b1;
        @(posedge clk);
        #1;
        sat_clr = 1'b0; op_valid = 1'b0;
        chk("R8 clear priority", {127'b0, sat_sticky}, 128'h0);

        // R9: disabled facility
        @(negedge clk);
        vec_en = 1'b0;
        apply(6'd8, {16{8'hFF}}, {16{8'hFF}});
        chk("R9 trap", {126'b0, unavail_trap, result_valid}, 128'h2);
        chk("R9 result", result, 128'h0);
        after_edge();
        chk("R9 sticky", {127'b0, sat_sticky}, 128'h0);
        vec_en = 1'b1;

        // R10: illegal opcodes (width code 3, then zero)
        apply(6'd11, {16{8'hFF}}, {16{8'hFF}});
        chk("R10 illegal 11", {126'b0, illegal_op, result_valid}, 128'h2);
        chk("R10 result", result, 128'h0);
        after_edge();
        chk("R10 sticky", {127'b0, sat_sticky}, 128'h0);
        apply(6'd0, {16{8'h80}}, {16{8'h80}});
        chk("R10 illegal 0", {126'b0, illegal_op, |result}, 128'h2);
        after_edge();
        chk("R10 sticky 0", {127'b0, sat_sticky}, 128'h0);

        // R12: no qualifier when op_valid low
        @(negedge clk);
        #1;
        chk("R12 idle", {125'b0, result_valid, illegal_op, unavail_trap}, 128'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule